// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregator

This block collects a vector of device interrupt lines into one request line toward a parent interrupt controller. Every register carries one bit per source. Software reads a pending image, changes a per-source disable mask through two write-one ports, and, in the latched variant, acknowledges captured events through a write-one clear port. The parent request is high whenever some pending bit has its disable bit at zero.

A parameter picks the variant when the block is built. With `LATCHED` set, a 0-to-1 transition on a source sets a sticky pending bit, which stays set until software clears it. With `LATCHED` cleared, the pending image is the input level taken through one register stage, and the block has no clear port. The two variants use different address maps.

The parent request comes from a two-state machine. `REQ_IDLE` goes to `REQ_RAISED` when any unmasked pending bit is seen. `REQ_RAISED` goes back to `REQ_IDLE` when no unmasked pending bit remains. In every other case the machine stays in its current state. Read data is registered and appears in the cycle after the read strobe.

Top module: `intr_gather`

## Requirements
- R1: After reset the mask reads all ones (every source disabled), the pending image reads zero, `irq_o` is low and `rdata_o` is zero.
- R2: Latched variant: a 0-to-1 transition of `src_i[k]` present before a clock edge sets pending bit k at that edge. The bit stays set after the input returns low.
- R3: Latched variant: writing the clear port sets to zero each pending bit whose write-data bit is 1. Bits written as 0 are unchanged. Writing all ones empties the whole image in one access.
- R4: Latched variant: when a new rising transition and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Level variant: pending bit k equals `src_i[k]` as sampled at the previous clock edge. An input held high keeps the request asserted for as long as it is unmasked.
- R6: A mask bit of 1 disables its source. Writing 1 to a bit of the mask-set port sets that mask bit, and writing 1 to a bit of the mask-clear port clears it. Bits written as 0 keep their value, and all ones takes effect in one access.
- R7: Reading the pending image returns every pending bit whatever the mask holds.
- R8: `irq_o` reflects the OR of (pending AND NOT mask) as it stood at the previous clock edge, so it rises or falls one cycle after the pending or mask change.
- R9: Byte offsets in the latched variant: pending 0x00, clear 0x08, mask image 0x0C, mask set 0x10, mask clear 0x14. Byte offsets in the level variant: pending 0x00, mask image 0x04, mask set 0x08, mask clear 0x0C.
- R10: Reads of unused offsets and of the write-only ports return zero. Writes to unused offsets change nothing.
- R11: `rdata_o` carries the selected register in the cycle after `rd_en_i` is high, and is zero in the cycle after `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | DATA_W | Device interrupt lines, one per source |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Request to the parent controller |

## Verification
The hardest case to reach from the ports is a rising transition on one bit in the same cycle as a clear write to that bit (R4). The bench raises `src_i` and asserts the clear write on one falling edge, so both act at the same rising edge. In that same write it also clears a second bit that was already pending. The readback then has to show the new bit set and the old bit gone. The one-cycle lag of the request (R8) is checked on both edges: the bench samples `irq_o` once in the cycle where a mask or clear write lands and once more in the following cycle.

// File: rtl/intr_gather_pkg.sv
package intr_gather_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_MSTAT,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    typedef enum logic {
        REQ_IDLE,
        REQ_RAISED
    } req_state_e;

endpackage

// File: rtl/intr_gather_decode.sv
module intr_gather_decode
    import intr_gather_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter bit LATCHED = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    localparam int OFF_STATUS = 0;
    localparam int OFF_CLEAR  = 8;
    localparam int OFF_MSTAT  = LATCHED ? 12 : 4;
    localparam int OFF_MSET   = LATCHED ? 16 : 8;
    localparam int OFF_MCLR   = LATCHED ? 20 : 12;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
    localparam logic [ADDR_W-1:0] A_MSTAT  = ADDR_W'(OFF_MSTAT);
    localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(OFF_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(OFF_MCLR);

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == A_STATUS) begin
            sel_o = SEL_STATUS;
        end else if (addr_i == A_MSTAT) begin
            sel_o = SEL_MSTAT;
        end else if (addr_i == A_MSET) begin
            sel_o = SEL_MSET;
        end else if (addr_i == A_MCLR) begin
            sel_o = SEL_MCLR;
        end else if (LATCHED && (addr_i == A_CLEAR)) begin
            sel_o = SEL_CLEAR;
        end
    end

endmodule

// File: rtl/intr_gather_status.sv
module intr_gather_status #(
    parameter int DATA_W  = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              clr_en_i,
    input  logic [DATA_W-1:0] clr_bits_i,
    output logic [DATA_W-1:0] status_o
);

    logic [DATA_W-1:0] status_q;

    generate
        if (LATCHED) begin : g_latch
            logic [DATA_W-1:0] prev_q;
            logic [DATA_W-1:0] edge_v;
            logic [DATA_W-1:0] kill_v;

            assign edge_v = src_i & ~prev_q;
            assign kill_v = clr_en_i ? clr_bits_i : '0;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q   <= '0;
                    status_q <= '0;
                end else begin
                    prev_q   <= src_i;
                    status_q <= (status_q & ~kill_v) | edge_v;
                end
            end

            // R2 R4
            edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|edge_v) |=> ((status_q & $past(edge_v)) == $past(edge_v)));

            // R3
            clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_en_i |=> ((status_q & $past(clr_bits_i) & ~$past(edge_v)) == '0));
        end else begin : g_level
            logic unused_clr;
            assign unused_clr = clr_en_i | (|clr_bits_i);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    status_q <= '0;
                end else begin
                    status_q <= src_i;
                end
            end
        end
    endgenerate

    assign status_o = status_q;

endmodule

// File: rtl/intr_gather_mask.sv
module intr_gather_mask #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic [DATA_W-1:0] bits_i,
    output logic [DATA_W-1:0] mask_o
);

    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (set_en_i) begin
            mask_q <= mask_q | bits_i;
        end else if (clr_en_i) begin
            mask_q <= mask_q & ~bits_i;
        end
    end

    assign mask_o = mask_q;

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));

    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> ((mask_q & $past(bits_i)) == '0));

    // R6
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en_i || clr_en_i) |=>
            ((mask_q & ~$past(bits_i)) == ($past(mask_q) & ~$past(bits_i))));

endmodule

// File: rtl/intr_gather.sv
module intr_gather
    import intr_gather_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter bit LATCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    reg_sel_e          sel_w;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] pend_w;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_clr;
    logic              wr_mset;
    logic              wr_mclr;
    req_state_e        state_q;
    req_state_e        state_d;

    intr_gather_decode #(
        .ADDR_W  (ADDR_W),
        .LATCHED (LATCHED)
    ) decode_i (
        .addr_i (addr_i),
        .sel_o  (sel_w)
    );

    assign wr_clr  = wr_en_i && (sel_w == SEL_CLEAR);
    assign wr_mset = wr_en_i && (sel_w == SEL_MSET);
    assign wr_mclr = wr_en_i && (sel_w == SEL_MCLR);

    intr_gather_status #(
        .DATA_W  (DATA_W),
        .LATCHED (LATCHED)
    ) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .clr_en_i   (wr_clr),
        .clr_bits_i (wdata_i),
        .status_o   (status_w)
    );

    intr_gather_mask #(
        .DATA_W (DATA_W)
    ) mask_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (wr_mset),
        .clr_en_i (wr_mclr),
        .bits_i   (wdata_i),
        .mask_o   (mask_w)
    );

    assign pend_w = status_w & ~mask_w;

    always_comb begin
        case (sel_w)
            SEL_STATUS: rd_mux = status_w;
            SEL_MSTAT:  rd_mux = mask_w;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_en_i ? rd_mux : '0;
        end
    end

    assign rdata_o = rdata_q;

    // request state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (|pend_w)  state_d = REQ_RAISED;
            REQ_RAISED: if (!(|pend_w)) state_d = REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    // request output
    always_comb begin
        irq_o = (state_q == REQ_RAISED);
    end

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|pend_w)));

    // R10
    rd_wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (sel_w != SEL_STATUS) && (sel_w != SEL_MSTAT)) |=> (rdata_o == '0));

    // R11
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == '0));

endmodule

// File: tb/intr_gather_tb_top.sv
module intr_gather_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] e_src = '0, v_src = '0;
    logic [AW-1:0] e_addr = '0, v_addr = '0;
    logic          e_wr = 1'b0, v_wr = 1'b0, e_rd = 1'b0, v_rd = 1'b0;
    logic [DW-1:0] e_wdata = '0, v_wdata = '0;
    logic [DW-1:0] e_rdata, v_rdata;
    logic          e_irq, v_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_gather #(.DATA_W(DW), .ADDR_W(AW), .LATCHED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(e_src), .addr_i(e_addr),
        .wr_en_i(e_wr), .wdata_i(e_wdata), .rd_en_i(e_rd),
        .rdata_o(e_rdata), .irq_o(e_irq));

    intr_gather #(.DATA_W(DW), .ADDR_W(AW), .LATCHED(1'b0)) dut_lvl_i (
        .clk(clk), .rst_n(rst_n), .src_i(v_src), .addr_i(v_addr),
        .wr_en_i(v_wr), .wdata_i(v_wdata), .rd_en_i(v_rd),
        .rdata_o(v_rdata), .irq_o(v_irq));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit lv, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (lv) begin v_wr = 1'b1; v_addr = a; v_wdata = d; end
        else    begin e_wr = 1'b1; e_addr = a; e_wdata = d; end
        @(negedge clk);
        v_wr = 1'b0; e_wr = 1'b0;
    endtask

    task automatic rd(input bit lv, input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        if (lv) begin v_rd = 1'b1; v_addr = a; end
        else    begin e_rd = 1'b1; e_addr = a; end
        @(negedge clk);
        d = lv ? v_rdata : e_rdata;
        v_rd = 1'b0; e_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        chk("R1 irq latched", {31'b0, e_irq}, 32'h0);
        chk("R1 irq level", {31'b0, v_irq}, 32'h0);
        chk("R1 rdata idle", e_rdata, 32'h0);
        rd(0, 8'h0C, d); chk("R1 mask latched", d, 32'hFFFF_FFFF);
        rd(0, 8'h00, d); chk("R1 status latched", d, 32'h0);
        rd(1, 8'h04, d); chk("R1 mask level", d, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R11 rdata zero after idle", e_rdata, 32'h0);
    endtask

    task automatic t_edge;
        logic [DW-1:0] d;
        @(negedge clk); e_src = 32'h1;
        @(negedge clk);
        chk("R7 irq masked", {31'b0, e_irq}, 32'h0);
        rd(0, 8'h00, d); chk("R7 raw status while masked", d, 32'h1);
        wr(0, 8'h14, 32'h1);
        chk("R8 irq lags unmask", {31'b0, e_irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq after unmask", {31'b0, e_irq}, 32'h1);
        e_src = 32'h0;
        repeat (2) @(negedge clk);
        rd(0, 8'h00, d); chk("R2 sticky after drop", d, 32'h1);
    endtask

    task automatic t_clear;
        logic [DW-1:0] d;
        wr(0, 8'h08, 32'h2);
        rd(0, 8'h00, d); chk("R3 zero bits no effect", d, 32'h1);
        wr(0, 8'h08, 32'h1);
        chk("R8 irq lags clear", {31'b0, e_irq}, 32'h1);
        @(negedge clk);
        chk("R8 irq drops", {31'b0, e_irq}, 32'h0);
        rd(0, 8'h00, d); chk("R3 cleared", d, 32'h0);
        @(negedge clk); e_src = 32'hA5A5_0000;
        @(negedge clk); e_src = 32'h0;
        rd(0, 8'h00, d); chk("R2 multi edge", d, 32'hA5A5_0000);
        wr(0, 8'h08, 32'hFFFF_FFFF);
        rd(0, 8'h00, d); chk("R3 clear all", d, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [DW-1:0] d;
        @(negedge clk); e_src = 32'h10;
        @(negedge clk); e_src = 32'h0;
        @(negedge clk);
        e_src = 32'h8; e_wr = 1'b1; e_addr = 8'h08; e_wdata = 32'h18;
        @(negedge clk);
        e_wr = 1'b0;
        rd(0, 8'h00, d); chk("R4 set wins over clear", d, 32'h8);
        e_src = 32'h0;
        wr(0, 8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask;
        logic [DW-1:0] d;
        wr(0, 8'h14, 32'h0000_FFFF);
        rd(0, 8'h0C, d); chk("R6 mask clear", d, 32'hFFFF_0000);
        wr(0, 8'h10, 32'h0000_0F00);
        rd(0, 8'h0C, d); chk("R6 mask set", d, 32'hFFFF_0F00);
        wr(0, 8'h10, 32'hFFFF_FFFF);
        rd(0, 8'h0C, d); chk("R6 mask set all", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_unused;
        logic [DW-1:0] d;
        @(negedge clk); e_src = 32'h200;
        @(negedge clk);
        wr(0, 8'h14, 32'h200);
        @(negedge clk);
        chk("R8 irq bit9", {31'b0, e_irq}, 32'h1);
        wr(0, 8'h18, 32'hFFFF_FFFF);
        wr(0, 8'h04, 32'hFFFF_FFFF);
        rd(0, 8'h00, d); chk("R10 write unused status", d, 32'h200);
        rd(0, 8'h0C, d); chk("R10 write unused mask", d, 32'hFFFF_FDFF);
        chk("R10 irq kept", {31'b0, e_irq}, 32'h1);
        rd(0, 8'h04, d); chk("R10 read 0x04", d, 32'h0);
        rd(0, 8'h08, d); chk("R10 read clear port", d, 32'h0);
        rd(0, 8'h10, d); chk("R10 read mask set port", d, 32'h0);
        rd(0, 8'h14, d); chk("R10 read mask clear port", d, 32'h0);
        rd(0, 8'h18, d); chk("R10 read 0x18", d, 32'h0);
        e_src = 32'h0;
        wr(0, 8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_level;
        logic [DW-1:0] d;
        @(negedge clk); v_src = 32'h81;
        @(negedge clk);
        rd(1, 8'h00, d); chk("R5 level status", d, 32'h81);
        chk("R7 level masked irq", {31'b0, v_irq}, 32'h0);
        wr(1, 8'h0C, 32'h80);
        @(negedge clk);
        chk("R8 level irq", {31'b0, v_irq}, 32'h1);
        rd(1, 8'h04, d); chk("R9 level mask image", d, 32'hFFFF_FF7F);
        wr(1, 8'h08, 32'h80);
        @(negedge clk);
        chk("R9 level mask set at 0x08", {31'b0, v_irq}, 32'h0);
        wr(1, 8'h0C, 32'h80);
        repeat (5) @(negedge clk);
        chk("R5 held high keeps irq", {31'b0, v_irq}, 32'h1);
        v_src = 32'h0;
        @(negedge clk);
        chk("R8 level irq lags drop", {31'b0, v_irq}, 32'h1);
        @(negedge clk);
        chk("R5 level irq drops", {31'b0, v_irq}, 32'h0);
        rd(1, 8'h00, d); chk("R5 level status low", d, 32'h0);
        rd(1, 8'h10, d); chk("R10 level read 0x10", d, 32'h0);
        wr(1, 8'h14, 32'hFFFF_FFFF);
        rd(1, 8'h04, d); chk("R10 level write unused", d, 32'hFFFF_FF7F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_clear();
        t_set_wins();
        t_mask();
        t_unused();
        t_level();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule